// File: doc/BRIEF.md
# Dual-Port Hardware Token Flags

This block is a bank of token flags that two independent ports, left and right, share. Each port has its own flag select, address, read/write strobe, output enable and data buses. Software on either side claims a flag by writing 0 to it. It then reads the flag back to learn whether the claim succeeded. It gives the flag up by writing 1. Each flag has a request latch per side. The side whose request arrives first owns the flag. A request from the other side is not lost: it waits in that side's latch and takes over ownership on the same clock edge that the owner releases.

Reads return the flag as the reading side sees it. The value is copied onto every data bit, so the owner reads all zeros and everyone else reads all ones. The value is captured when the access starts and is held unchanged for as long as the access lasts. A write from the far side during a read therefore cannot change what the reader sees.

Everything is synchronous to one clock. A synchronous reset frees every flag.

Top module: `token_flag_bank`

## Requirements
- R1: After reset every flag is free: a read of any flag from either side returns 8'hFF with the valid output high.
- R2: A write of 0 to a free flag claims it for the writing side. On later reads that side gets 8'h00 and the other side gets 8'hFF.
- R3: A write uses only data bit 0, and bits 7:1 are ignored. The 3-bit address picks one of eight independent flags. A write with the select high (inactive) changes nothing.
- R4: A write of 0 from the non-owning side leaves an owned flag unchanged: the owner still reads 8'h00 and the other side still reads 8'hFF.
- R5: When the owner writes 1 while the opposite side has a pending request, ownership passes directly to the opposite side on that clock edge.
- R6: When the owner writes 1 and the other side has no pending request, the flag becomes free.
- R7: When both sides write 0 to the same free flag on the same clock edge, the left side is granted and the right request stays pending.
- R8: When two requests reach a free flag on different edges, the earlier request wins.
- R9: A read value is captured on the first edge where select and output enable are both low. It stays constant while both stay low, even if the flag changes underneath.
- R10: When select or output enable is high at a clock edge, the read data is 0 and valid is low after that edge. Valid rises after the first edge of an access.
- R11: A request stays latched until its own side writes 1. A pending request that its own side withdraws no longer takes over the flag on release.
- R12: Whatever the prior state, writing 1 from both sides to every flag leaves all flags free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; frees all flags |
| l_sel_n | input | 1 | Left flag select, active low |
| l_addr | input | 3 | Left flag address |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wdata | input | 8 | Left write data; only bit 0 is used |
| l_rdata | output | 8 | Left read data, all ones or all zeros |
| l_rvalid | output | 1 | Left read data valid |
| r_sel_n | input | 1 | Right flag select, active low |
| r_addr | input | 3 | Right flag address |
| r_wr | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wdata | input | 8 | Right write data; only bit 0 is used |
| r_rdata | output | 8 | Right read data, all ones or all zeros |
| r_rvalid | output | 1 | Right read data valid |

## Verification
A write changes flag ownership on the edge that samples it. A read that starts on the next edge already reflects that write. Read data and valid appear one edge after the access begins. They return to zero one edge after select or output enable goes high. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each result is read half a cycle after the edge that produced it. The hold test keeps the access open over several edges while the far port releases the flag, and it checks the held value at each falling edge.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Request latches are active low: 0 = request present.
    typedef struct packed {
        logic   req_l;
        logic   req_r;
        owner_e owner;
    } cell_t;

endpackage

// File: rtl/tfb_cell.sv
module tfb_cell
    import tfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_l,
    input  logic bit_l,
    input  logic wr_r,
    input  logic bit_r,
    output logic flag_l_n,
    output logic flag_r_n
);

    cell_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_l) s_d.req_l = bit_l;
        if (wr_r) s_d.req_r = bit_r;
        case (s_q.owner)
            OWN_LEFT:  if (s_d.req_l) s_d.owner = s_d.req_r ? OWN_NONE : OWN_RIGHT;
            OWN_RIGHT: if (s_d.req_r) s_d.owner = s_d.req_l ? OWN_NONE : OWN_LEFT;
            default: begin
                if (!s_d.req_l)      s_d.owner = OWN_LEFT;
                else if (!s_d.req_r) s_d.owner = OWN_RIGHT;
                else                 s_d.owner = OWN_NONE;
            end
        endcase
        if (!rst_n) begin
            s_d.req_l = 1'b1;
            s_d.req_r = 1'b1;
            s_d.owner = OWN_NONE;
        end
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign flag_l_n = (s_q.owner != OWN_LEFT);
    assign flag_r_n = (s_q.owner != OWN_RIGHT);

    // Owner encoding never takes the unused value
    p_owner_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.owner != 2'd3);

    // An owner always holds its own request (R11)
    p_owner_holds_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.owner == OWN_LEFT) |-> !s_q.req_l) and ((s_q.owner == OWN_RIGHT) |-> !s_q.req_r));

    // A non-owner request cannot take an owned flag
    p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.owner == OWN_LEFT && !wr_l && wr_r && !bit_r) |=> (s_q.owner == OWN_LEFT));

    // Release with pending opposite request hands over at once
    p_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.owner == OWN_RIGHT && wr_r && bit_r && !wr_l && !s_q.req_l) |=> (s_q.owner == OWN_LEFT));

    // Same-edge tie on a free flag goes to the left
    p_tie_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.owner == OWN_NONE && wr_l && !bit_l) |=> (s_q.owner == OWN_LEFT));

endmodule

// File: rtl/tfb_rd_port.sv
module tfb_rd_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              flag_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic              active;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t r_d, r_q;
    logic access;

    assign access = !sel_n && !oe_n;

    always_comb begin
        r_d = r_q;
        if (!access) begin
            r_d.active = 1'b0;
            r_d.data   = '0;
        end else if (!r_q.active) begin
            r_d.active = 1'b1;
            r_d.data   = {DATA_W{flag_n}};
        end
        if (!rst_n) r_d = '0;
    end

    always_ff @(posedge clk) r_q <= r_d;

    assign rdata  = r_q.data;
    assign rvalid = r_q.active;

    // Held value stays frozen while the access continues
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && access) |=> $stable(rdata));

    // Idle access clears data and valid
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> (!rvalid && rdata == '0));

    // Read data is always a uniform word
    p_uniform_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata == '0) || (rdata == '1));

endmodule

// File: rtl/token_flag_bank.sv
module token_flag_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              l_oe_n,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              r_sel_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              r_oe_n,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);

    logic [NUM_FLAGS-1:0] fl_n, fr_n;
    logic l_wen, r_wen;

    assign l_wen = !l_sel_n && l_wr;
    assign r_wen = !r_sel_n && r_wr;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cell
        tfb_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_l     (l_wen && (l_addr == ADDR_W'(i))),
            .bit_l    (l_wdata[0]),
            .wr_r     (r_wen && (r_addr == ADDR_W'(i))),
            .bit_r    (r_wdata[0]),
            .flag_l_n (fl_n[i]),
            .flag_r_n (fr_n[i])
        );
    end

    tfb_rd_port #(.DATA_W(DATA_W)) u_rd_l (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (l_sel_n),
        .oe_n   (l_oe_n),
        .flag_n (fl_n[l_addr]),
        .rdata  (l_rdata),
        .rvalid (l_rvalid)
    );

    tfb_rd_port #(.DATA_W(DATA_W)) u_rd_r (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (r_sel_n),
        .oe_n   (r_oe_n),
        .flag_n (fr_n[r_addr]),
        .rdata  (r_rdata),
        .rvalid (r_rvalid)
    );

    // A flag is never owned by both sides at once
    p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (~fl_n & ~fr_n) == '0);

endmodule

// File: tb/token_flag_bank_tb.sv
module token_flag_bank_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel_n = 1'b1, l_wr = 1'b0, l_oe_n = 1'b1;
    logic [2:0] l_addr = '0;
    logic [7:0] l_wdata = '0;
    logic       r_sel_n = 1'b1, r_wr = 1'b0, r_oe_n = 1'b1;
    logic [2:0] r_addr = '0;
    logic [7:0] r_wdata = '0;
    logic [7:0] l_rdata, r_rdata;
    logic       l_rvalid, r_rvalid;

    int vectors = 0;
    int miscompares = 0;
    int mown [8];   // 0 free, 1 left, 2 right
    bit mreq_l [8]; // active low request
    bit mreq_r [8];

    always #10 clk = ~clk;

    token_flag_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_addr(l_addr), .l_wr(l_wr), .l_oe_n(l_oe_n),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .r_sel_n(r_sel_n), .r_addr(r_addr), .r_wr(r_wr), .r_oe_n(r_oe_n),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_l(input int a);
        return (mown[a] == 1) ? 8'h00 : 8'hFF;
    endfunction
    function automatic logic [7:0] exp_r(input int a);
        return (mown[a] == 2) ? 8'h00 : 8'hFF;
    endfunction

    // Requirement model: requests latch, then ownership resolves
    task automatic mdl(input bit wl, input int al, input bit bl,
                       input bit wr, input int ar, input bit br);
        if (wl) mreq_l[al] = bl;
        if (wr) mreq_r[ar] = br;
        for (int i = 0; i < 8; i++) begin
            if (mown[i] == 1 && mreq_l[i]) mown[i] = mreq_r[i] ? 0 : 2;
            else if (mown[i] == 2 && mreq_r[i]) mown[i] = mreq_l[i] ? 0 : 1;
            else if (mown[i] == 0) mown[i] = !mreq_l[i] ? 1 : (!mreq_r[i] ? 2 : 0);
        end
    endtask

    task automatic mdl_reset();
        for (int i = 0; i < 8; i++) begin
            mown[i] = 0; mreq_l[i] = 1; mreq_r[i] = 1;
        end
    endtask

    // One write cycle; sl/sr = select asserted, wl/wr = write strobe
    task automatic do_wr(input bit sl, input bit wl, input int al, input logic [7:0] dl,
                         input bit sr, input bit wr, input int ar, input logic [7:0] dr);
        @(negedge clk);
        l_sel_n = !sl; l_wr = wl; l_oe_n = 1'b1; l_addr = 3'(al); l_wdata = dl;
        r_sel_n = !sr; r_wr = wr; r_oe_n = 1'b1; r_addr = 3'(ar); r_wdata = dr;
        @(posedge clk);
        @(negedge clk);
        l_sel_n = 1'b1; l_wr = 1'b0; r_sel_n = 1'b1; r_wr = 1'b0;
        mdl(sl && wl, al, dl[0], sr && wr, ar, dr[0]);
    endtask

    // Read both sides, check values and valid, then check idle outputs
    task automatic rd_chk(input string req, input int al, input int ar);
        @(negedge clk);
        l_sel_n = 1'b0; l_oe_n = 1'b0; l_wr = 1'b0; l_addr = 3'(al);
        r_sel_n = 1'b0; r_oe_n = 1'b0; r_wr = 1'b0; r_addr = 3'(ar);
        @(posedge clk);
        @(negedge clk);
        chk({req, " left"}, l_rdata, exp_l(al));
        chk({req, " right"}, r_rdata, exp_r(ar));
        chk("R10 valid", {6'd0, l_rvalid, r_rvalid}, 8'h03);
        l_sel_n = 1'b1; l_oe_n = 1'b1; r_sel_n = 1'b1; r_oe_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 idle", {l_rdata | r_rdata} | {6'd0, l_rvalid, r_rvalid}, 8'h00);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        mdl_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: everything free after reset
        for (int a = 0; a < 8; a++) rd_chk("R1", a, 7 - a);

        // R2: claim; R3: only bit 0 matters, neighbour untouched
        do_wr(1, 1, 2, 8'hFE, 0, 0, 0, 8'h00);
        rd_chk("R2", 2, 2);
        chk("R2 model", exp_l(2), 8'h00);
        rd_chk("R3 neighbour", 3, 1);
        // R4: right request blocked
        do_wr(0, 0, 0, 8'h00, 1, 1, 2, 8'h00);
        rd_chk("R4", 2, 2);
        // R5: left release hands to pending right
        do_wr(1, 1, 2, 8'h01, 0, 0, 0, 8'h00);
        rd_chk("R5", 2, 2);
        chk("R5 model", exp_r(2), 8'h00);
        // R11: left requests then withdraws; right release frees (R6)
        do_wr(1, 1, 2, 8'h00, 0, 0, 0, 8'h00);
        do_wr(1, 1, 2, 8'hFF, 0, 0, 0, 8'h00);
        do_wr(0, 0, 0, 8'h00, 1, 1, 2, 8'h01);
        rd_chk("R11 R6", 2, 2);
        chk("R6 model", exp_l(2) & exp_r(2), 8'hFF);
        // R3: write with select inactive changes nothing
        do_wr(0, 1, 4, 8'h00, 0, 1, 4, 8'h00);
        rd_chk("R3 deselected", 4, 4);
        // R7: same-edge tie to left, right pending
        do_wr(1, 1, 5, 8'h00, 1, 1, 5, 8'h00);
        rd_chk("R7 tie", 5, 5);
        chk("R7 model", exp_l(5), 8'h00);
        do_wr(1, 1, 5, 8'h01, 0, 0, 0, 8'h00);
        rd_chk("R7 pending", 5, 5);
        do_wr(0, 0, 0, 8'h00, 1, 1, 5, 8'h01);
        // R8: earlier right request wins
        do_wr(0, 0, 0, 8'h00, 1, 1, 6, 8'h00);
        do_wr(1, 1, 6, 8'h00, 0, 0, 0, 8'h00);
        rd_chk("R8", 6, 6);
        chk("R8 model", exp_r(6), 8'h00);
        do_wr(1, 1, 6, 8'h01, 1, 1, 6, 8'h01);

        // R9: left read held across a handoff to left
        do_wr(0, 0, 0, 8'h00, 1, 1, 3, 8'h00);
        do_wr(1, 1, 3, 8'h00, 0, 0, 0, 8'h00);
        @(negedge clk);
        l_sel_n = 1'b0; l_oe_n = 1'b0; l_wr = 1'b0; l_addr = 3'd3;
        @(posedge clk);
        @(negedge clk);
        chk("R9 start", l_rdata, 8'hFF);
        r_sel_n = 1'b0; r_wr = 1'b1; r_addr = 3'd3; r_wdata = 8'h01;
        @(posedge clk);
        @(negedge clk);
        mdl(0, 0, 0, 1, 3, 1);
        r_sel_n = 1'b1; r_wr = 1'b0;
        chk("R9 held", l_rdata, 8'hFF);
        @(posedge clk);
        @(negedge clk);
        chk("R9 held later", l_rdata, 8'hFF);
        l_sel_n = 1'b1; l_oe_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 end", {l_rdata[7:1], l_rvalid}, 8'h00);
        rd_chk("R9 fresh", 3, 3);
        chk("R9 model", exp_l(3), 8'h00);
        do_wr(1, 1, 3, 8'h01, 0, 0, 0, 8'h00);

        // Near-exhaustive sweep: every flag, pair and data bit, model-checked
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int op = 0; op < 8; op++) begin
                    do_wr(op[0] | op[2], 1, a, {$urandom % 128, op[1]}[7:0],
                          !op[0] | op[2], 1, b, {$urandom % 128, op[2]}[7:0]);
                    rd_chk("R2/R3/R4/R5/R6/R7/R8", a, b);
                end

        // R12: scramble, then double release frees all
        for (int a = 0; a < 8; a++) do_wr(1, 1, a, 8'h00, 1, 1, 7 - a, 8'h00);
        for (int a = 0; a < 8; a++) do_wr(1, 1, a, 8'h01, 1, 1, a, 8'h01);
        for (int a = 0; a < 8; a++) begin
            rd_chk("R12", a, a);
            chk("R12 model", exp_l(a) & exp_r(a), 8'hFF);
        end

        summary();
        $finish;
    end

endmodule